// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This block runs one indivisible read-then-write sequence on a word memory on behalf of a core's register file. A request carries an operation code, a word address, the values of two consecutive registers (the first, or even, register and the second, or odd, register) and the index of the first register. The sequencer reads the addressed word and computes a replacement from the old word and the two register values. It writes the replacement back and then returns the old word with a completion pulse. A lock output is held from the read through the write acknowledge, so that an external arbiter can keep every other master off the memory for the whole sequence.

Four operations are supported. Exchange stores the first register and returns the old word. Conditional exchange stores the first register only when the old word equals the second register; otherwise it writes the old word back unchanged. Masked exchange merges the first register into the old word, with the second register as a bit mask, and returns the old word. Masked merge performs the same bit merge but does not ask for a register writeback. Three of the operations need a register pair, which must start on an even index. An odd index makes the sequencer report an operand trap and issue no memory cycle. Memory words are 32 bits, little-endian: bits 7:0 belong to the lowest byte address of the word. Addresses are given as word indexes.

Top module: `rmw_atomic_unit`

## Requirements
- R1: Operation code 0 (exchange) writes the first register value to the addressed word and returns the previous word on respData with respWb high; an odd register index does not trap for this code.
- R2: Operation code 1 (conditional exchange) with an old word equal to the second register writes the first register value to memory.
- R3: Operation code 1 with an old word different from the second register writes the unchanged old word back, still issuing exactly one write.
- R4: Operation code 2 (masked exchange) writes (first AND second) OR (old AND NOT second), with the second register as the mask.
- R5: Operation code 3 (masked merge) writes (old AND NOT odd) OR (even AND odd), where the data is the even (first) register and the mask is the odd (second) register.
- R6: Every completed operation returns the old memory word on respData. respWb is high for codes 0, 1 and 2 and low for code 3. respIdx echoes the request's register index.
- R7: For codes 1, 2 and 3, a register index with bit 0 set gives respTrap and respDone together for one cycle, with no memory read, no memory write and respWb low.
- R8: A non-trapping operation performs exactly one read and then exactly one write, both at the request's word address.
- R9: memLock is high on every cycle from the first read request through the cycle of the write acknowledge, and memRd or memWr is never high without memLock.
- R10: After reset the sequencer is idle: reqReady high, and memRd, memWr, memLock and respDone low. respDone lasts exactly one cycle, and reqReady is high only while idle.
- R11: memAck stalls the read and the write for any number of wait cycles without changing the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present; taken on a clock edge while reqReady is high |
| reqReady | output | 1 | Sequencer idle and able to take a request |
| reqOp | input | 2 | 0 exchange, 1 conditional exchange, 2 masked exchange, 3 masked merge |
| reqAddr | input | ADDR_W | Word address of the target |
| reqRegA | input | DATA_W | First (even) register value: store data |
| reqRegB | input | DATA_W | Second (odd) register value: compare value or mask |
| reqRegIdx | input | IDX_W | Index of the first register |
| respDone | output | 1 | One-cycle completion pulse |
| respTrap | output | 1 | Operand trap, valid with respDone |
| respWb | output | 1 | respData is to be written to the first register |
| respIdx | output | IDX_W | Register index of the completed request |
| respData | output | DATA_W | Old memory word |
| memRd | output | 1 | Read request, held until memAck |
| memWr | output | 1 | Write request, held until memAck |
| memLock | output | 1 | Memory must stay reserved for this sequence |
| memAddr | output | ADDR_W | Word address of the memory cycle |
| memWdata | output | DATA_W | Write data, little-endian byte lanes |
| memRdata | input | DATA_W | Read data, valid with memAck during a read |
| memAck | input | 1 | Memory cycle accepted or completed |

## Verification
A wrong sequencer state shows at the memory port within one or two cycles of the request: a missing or doubled read or write, a write issued with the lock low, or a memory cycle that follows a trapping request. A wrong capture or merge in the datapath shows only after completion, as a wrong final memory word or a wrong respData. For that reason the sweep checks the stored word after every operation, across every code, every register index and both compare outcomes, with zero, one and two wait cycles on memAck.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  typedef enum logic [1:0] {
    OP_XCHG   = 2'd0,
    OP_CMPXCH = 2'd1,
    OP_MSKXCH = 2'd2,
    OP_MERGE  = 2'd3
  } rmwOp_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_MODIFY = 3'd2,
    ST_WRITE  = 3'd3,
    ST_DONE   = 3'd4
  } rmwState_e;

  // strobes from the sequencer into the datapath
  typedef struct packed {
    logic loadReq;   // latch the request fields
    logic loadOld;   // latch the word returned by the read
    logic loadNew;   // latch the computed replacement word
  } rmwStrobe_t;

endpackage

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       pairFault,
  input  logic       memAck,
  output rmwStrobe_t strobe,
  output logic       reqReady,
  output logic       memRd,
  output logic       memWr,
  output logic       memLock,
  output logic       respDone,
  output logic       respTrap
);

  rmwState_e state, stateNext;
  logic      trapQ;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (reqValid) stateNext = pairFault ? ST_DONE : ST_READ;
      ST_READ:   if (memAck)   stateNext = ST_MODIFY;
      ST_MODIFY:               stateNext = ST_WRITE;
      ST_WRITE:  if (memAck)   stateNext = ST_DONE;
      ST_DONE:                 stateNext = ST_IDLE;
      default:                 stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      trapQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && reqValid) trapQ <= pairFault;
    end
  end

  always_comb begin
    strobe.loadReq = (state == ST_IDLE) && reqValid;
    strobe.loadOld = (state == ST_READ) && memAck;
    strobe.loadNew = (state == ST_MODIFY);
  end

  assign reqReady = (state == ST_IDLE);
  assign memRd    = (state == ST_READ);
  assign memWr    = (state == ST_WRITE);
  assign memLock  = (state == ST_READ) || (state == ST_MODIFY) || (state == ST_WRITE);
  assign respDone = (state == ST_DONE);
  assign respTrap = (state == ST_DONE) && trapQ;

  // R9
  lock_cover_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |-> memLock);

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && memAck) |=> memLock);

  // R7
  trap_no_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid && pairFault) |=> (!memRd && !memWr && respTrap));

  // R7
  trap_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    respTrap |-> respDone);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    respDone |=> !respDone);

  // R8
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  // R11
  read_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !memAck) |=> memRd);

  // R11
  write_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && !memAck) |=> memWr);

endmodule

// File: rtl/rmw_dpath.sv
module rmw_dpath
  import rmw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  rmwStrobe_t        strobe,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqRegA,
  input  logic [DATA_W-1:0] reqRegB,
  input  logic [IDX_W-1:0]  reqRegIdx,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              trapFlag,
  output logic              pairFault,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] respData,
  output logic [IDX_W-1:0]  respIdx,
  output logic              respWb
);

  rmwOp_e            opQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] regAQ, regBQ, oldQ, newQ;
  logic [IDX_W-1:0]  idxQ;
  logic [DATA_W-1:0] mergeWord, newWord;

  // pair operands must start on an even register
  assign pairFault = reqRegIdx[0] && (rmwOp_e'(reqOp) != OP_XCHG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ   <= OP_XCHG;
      addrQ <= '0;
      regAQ <= '0;
      regBQ <= '0;
      idxQ  <= '0;
      oldQ  <= '0;
      newQ  <= '0;
    end else begin
      if (strobe.loadReq) begin
        opQ   <= rmwOp_e'(reqOp);
        addrQ <= reqAddr;
        regAQ <= reqRegA;
        regBQ <= reqRegB;
        idxQ  <= reqRegIdx;
      end
      if (strobe.loadOld) oldQ <= memRdata;
      if (strobe.loadNew) newQ <= newWord;
    end
  end

  // bitwise merge: mask bit set takes the register bit, clear keeps memory
  for (genvar b = 0; b < DATA_W; b++) begin : g_merge
    assign mergeWord[b] = regBQ[b] ? regAQ[b] : oldQ[b];
  end

  always_comb begin
    unique case (opQ)
      OP_XCHG:   newWord = regAQ;
      OP_CMPXCH: newWord = (oldQ == regBQ) ? regAQ : oldQ;
      OP_MSKXCH: newWord = mergeWord;
      OP_MERGE:  newWord = mergeWord;
      default:   newWord = oldQ;
    endcase
  end

  assign memAddr  = addrQ;
  assign memWdata = newQ;
  assign respData = oldQ;
  assign respIdx  = idxQ;
  assign respWb   = !trapFlag && (opQ != OP_MERGE);

  // R3
  cmp_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadNew && opQ == OP_CMPXCH && oldQ != regBQ) |=> (memWdata == oldQ));

  // R6
  old_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadNew |=> $stable(respData));

endmodule

// File: rtl/rmw_atomic_unit.sv
module rmw_atomic_unit
  import rmw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqRegA,
  input  logic [DATA_W-1:0] reqRegB,
  input  logic [IDX_W-1:0]  reqRegIdx,
  output logic              respDone,
  output logic              respTrap,
  output logic              respWb,
  output logic [IDX_W-1:0]  respIdx,
  output logic [DATA_W-1:0] respData,
  output logic              memRd,
  output logic              memWr,
  output logic              memLock,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck
);

  rmwStrobe_t strobe;
  logic       pairFault;
  logic       trapLine;

  rmw_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .pairFault(pairFault),
    .memAck   (memAck),
    .strobe   (strobe),
    .reqReady (reqReady),
    .memRd    (memRd),
    .memWr    (memWr),
    .memLock  (memLock),
    .respDone (respDone),
    .respTrap (trapLine)
  );

  rmw_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqOp    (reqOp),
    .reqAddr  (reqAddr),
    .reqRegA  (reqRegA),
    .reqRegB  (reqRegB),
    .reqRegIdx(reqRegIdx),
    .memRdata (memRdata),
    .trapFlag (trapLine),
    .pairFault(pairFault),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .respData (respData),
    .respIdx  (respIdx),
    .respWb   (respWb)
  );

  assign respTrap = trapLine;

endmodule

// File: tb/sim_rmw_atomic_unit.sv
`timescale 1ns/1ps
module sim_rmw_atomic_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqOp = '0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqRegA = '0;
  logic [31:0] reqRegB = '0;
  logic [3:0]  reqRegIdx = '0;
  logic        respDone, respTrap, respWb;
  logic [3:0]  respIdx;
  logic [31:0] respData;
  logic        memRd, memWr, memLock, memAck;
  logic [31:0] memAddr, memWdata, memRdata;

  always #4 clk = ~clk;  // 125 MHz

  rmw_atomic_unit u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqRegA(reqRegA), .reqRegB(reqRegB),
    .reqRegIdx(reqRegIdx), .respDone(respDone), .respTrap(respTrap),
    .respWb(respWb), .respIdx(respIdx), .respData(respData),
    .memRd(memRd), .memWr(memWr), .memLock(memLock), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck)
  );

  // word memory model with programmable wait cycles (R11)
  logic [31:0] memArr [16];
  int          latSel = 0;
  int          latCnt = 0;
  logic        presetEn = 1'b0;
  logic [3:0]  presetIdx = '0;
  logic [31:0] presetVal = '0;

  assign memAck   = (memRd || memWr) && (latCnt >= latSel);
  assign memRdata = memArr[memAddr[3:0]];

  always @(posedge clk) begin
    if ((memRd || memWr) && !memAck) latCnt <= latCnt + 1;
    else latCnt <= 0;
    if (memWr && memAck) memArr[memAddr[3:0]] <= memWdata;
    else if (presetEn) memArr[presetIdx] <= presetVal;
  end

  int  errors = 0;
  int  checks = 0;
  bit  finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input int op, input int idx, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] init,
                       input int slot, input int lat);
    int rdN = 0, wrN = 0, lockBreak = 0;
    bit gotDone = 0, gotTrap = 0, gotWb = 0;
    logic [31:0] gotData = '0, rdAddr = '0, wrAddr = '0;
    logic [3:0]  gotIdx = '0;
    logic [31:0] addr, expNew, expMem;
    bit expTrap, expWb;
    addr = 32'h0000_1230 | 32'(slot);
    expTrap = (op != 0) && idx[0];
    unique case (op)
      0: expNew = a;
      1: expNew = (init == b) ? a : init;
      default: expNew = (a & b) | (init & ~b);
    endcase
    expMem = expTrap ? init : expNew;
    expWb  = !expTrap && (op != 3);

    @(negedge clk);
    presetEn = 1; presetIdx = 4'(slot); presetVal = init; latSel = lat;
    @(negedge clk);
    presetEn = 0;
    chk(reqReady == 1'b1, "R10 ready-idle", 32'(reqReady), 32'd1);
    reqValid = 1; reqOp = 2'(op); reqAddr = addr; reqRegA = a; reqRegB = b;
    reqRegIdx = 4'(idx);
    @(negedge clk);
    reqValid = 0;
    for (int c = 0; c < 60; c++) begin
      if (memRd && memAck) begin rdN++; rdAddr = memAddr; end
      if (memWr && memAck) begin wrN++; wrAddr = memAddr; end
      if (rdN > 0 && wrN == 0 && !memLock) lockBreak++;
      if ((memRd || memWr) && !memLock) lockBreak++;
      if (respDone) begin
        gotDone = 1; gotTrap = respTrap; gotWb = respWb;
        gotData = respData; gotIdx = respIdx;
        break;
      end
      if (reqReady) lockBreak += 0;
      @(negedge clk);
    end
    chk(gotDone, "R8 completion", 32'(gotDone), 32'd1);
    @(negedge clk);
    chk(!respDone, "R10 done-pulse", 32'(respDone), 32'd0);
    chk(gotTrap == expTrap, expTrap ? "R7 trap" : (op == 0 ? "R1 no-trap" : "R8 no-trap"),
        32'(gotTrap), 32'(expTrap));
    chk(rdN == (expTrap ? 0 : 1), expTrap ? "R7 reads" : (lat > 0 ? "R11 reads" : "R8 reads"),
        32'(rdN), expTrap ? 32'd0 : 32'd1);
    chk(wrN == (expTrap ? 0 : 1), expTrap ? "R7 writes" : (op == 1 ? "R3 writes" : "R8 writes"),
        32'(wrN), expTrap ? 32'd0 : 32'd1);
    chk(lockBreak == 0, "R9 lock", 32'(lockBreak), 32'd0);
    chk(gotWb == expWb, "R6 wb", 32'(gotWb), 32'(expWb));
    chk(gotIdx == 4'(idx), "R6 idx", 32'(gotIdx), 32'(idx));
    if (!expTrap) begin
      chk(gotData == init, "R6 old", gotData, init);
      chk(rdAddr == addr && wrAddr == addr, "R8 addr", wrAddr, addr);
    end
    unique case (op)
      0: chk(memArr[slot] == expMem, expTrap ? "R7 mem" : "R1 mem", memArr[slot], expMem);
      1: chk(memArr[slot] == expMem, (init == b) ? "R2 mem" : "R3 mem", memArr[slot], expMem);
      2: chk(memArr[slot] == expMem, expTrap ? "R7 mem" : "R4 mem", memArr[slot], expMem);
      default: chk(memArr[slot] == expMem, expTrap ? "R7 mem" : "R5 mem", memArr[slot], expMem);
    endcase
  endtask

  initial begin
    for (int i = 0; i < 16; i++) memArr[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(reqReady == 1'b1, "R10 reset ready", 32'(reqReady), 32'd1);
    chk(!memRd && !memWr && !memLock, "R10 reset mem",
        {29'd0, memRd, memWr, memLock}, 32'd0);
    chk(!respDone, "R10 reset done", 32'(respDone), 32'd0);
    rstN = 1;
    @(negedge clk);
    for (int op = 0; op < 4; op++) begin
      for (int idx = 0; idx < 16; idx++) begin
        for (int p = 0; p < 4; p++) begin
          logic [31:0] a, b, init;
          int k;
          k = op * 64 + idx * 4 + p;
          a    = 32'h9E37_79B9 * 32'(k + 1);
          init = 32'h85EB_CA6B * 32'(k + 3) ^ 32'h0F0F_00FF;
          b    = (p[0]) ? init : (32'hC2B2_AE35 * 32'(k + 7));
          if (p == 3) b = 32'hFFFF_0000;
          runOp(op, idx, a, b, init, (k % 16), p % 3);
        end
      end
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule